// File: doc/BRIEF.md
# Layered Display Pixel Address Generator

This block turns a raster position into the memory byte address of the pixel that each display layer must fetch. It serves five address paths: a foreground plane with two selectable origins, a background plane at origin zero that scrolls and wraps, a video window with three selectable origins, and two cursor tiles of 32×32 pixels with origins of their own. A layer takes part in a cycle when its bit in the request vector is set. One cycle later the address and a valid flag for that layer come out of registers.

Foreground and background share two mode bits. One sets the pixel size to one or two bytes. The other sets the plane line length to 512 or 1024 pixels. The video window uses its own width as its line length, and its pixel size comes from a format bit. The two buffer-select inputs are latched only on a frame-start pulse, so every fetch in a frame reads from the same buffer.

Top module: `disp_addr_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all valid flags are 0.
- R2: Valid bit i (0 foreground, 1 background, 2 video, 3 cursor 0, 4 cursor 1) is 1 exactly one cycle after request bit i was 1 and that layer's position was in range, and 0 otherwise.
- R3: Foreground address = chosen origin + (y·L + x)·B. L is 512 when `wide`=0 and 1024 when `wide`=1. B is 1 when `pix16`=0 and 2 when `pix16`=1. The address is valid only when x < L.
- R4: `fg_sel` (0 selects `fg_base0`, 1 selects `fg_base1`) and `vid_sel` (0, 1, 2 select `vid_base0..2`) act only from the cycle after a cycle with `frame_start`=1.
- R5: A `vid_sel` value of 3 latched at frame start is ignored, and the previous video buffer stays in use.
- R6: Background column = (x + `bg_x0`) mod L. Address = (row·L + column)·B, with origin zero.
- R7: Background row = y + `bg_y0`, minus `bg_h` when the sum is at least `bg_h`. This assumes y and `bg_y0` are both below `bg_h`.
- R8: Video address = chosen origin + (y·`vid_w` + x)·V. V is 2 when `vid_ycc`=1 and 1 when `vid_ycc`=0.
- R9: The video address is valid only when x < `vid_w` and y < `vid_h`.
- R10: Cursor k address = `cur_basek` + y·32 + x, valid only when x < 32 and y < 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frame_start | input | 1 | Pulse at vertical blank; latches buffer selects |
| fg_sel | input | 1 | Foreground buffer select request |
| vid_sel | input | 2 | Video buffer select request |
| fg_base0 | input | AW | Foreground origin, buffer 0 |
| fg_base1 | input | AW | Foreground origin, buffer 1 |
| vid_base0 | input | AW | Video origin, buffer 0 |
| vid_base1 | input | AW | Video origin, buffer 1 |
| vid_base2 | input | AW | Video origin, buffer 2 |
| cur_base0 | input | AW | Cursor 0 origin |
| cur_base1 | input | AW | Cursor 1 origin |
| bg_x0 | input | XW | Background scroll start column |
| bg_y0 | input | YW | Background scroll start row |
| bg_h | input | YW | Background plane height in lines |
| pix16 | input | 1 | Foreground/background 2 bytes per pixel |
| wide | input | 1 | Line length 1024 instead of 512 |
| vid_ycc | input | 1 | Video 2 bytes per pixel (YCbCr) instead of 1 |
| vid_w | input | XW | Video window width |
| vid_h | input | YW | Video window height |
| x | input | XW | Layer column of the fetch |
| y | input | YW | Layer row of the fetch |
| req | input | 5 | Per-layer fetch request |
| addr_fg | output | AW | Foreground byte address |
| addr_bg | output | AW | Background byte address |
| addr_vid | output | AW | Video byte address |
| addr_cur0 | output | AW | Cursor 0 byte address |
| addr_cur1 | output | AW | Cursor 1 byte address |
| vld | output | 5 | Per-layer address valid |

## Verification
The only state the block keeps is the two latched buffer indices. If one of them is wrong, the next fetch of that layer shows it at the address port as an origin off by exactly one base register, one cycle after the request, and the error persists until the next frame start. Errors in stride, pixel size or wrap appear in the same cycle as a fixed offset pattern in the address. A wrong window bound appears as a valid flag that is raised or missing for the edge pixels.

// File: rtl/disp_addr_gen.sv
module disp_addr_gen #(
  parameter int AW  = 32,
  parameter int XW  = 11,
  parameter int YW  = 10,
  parameter int CUR = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          fg_sel,
  input  logic [1:0]    vid_sel,
  input  logic [AW-1:0] fg_base0,
  input  logic [AW-1:0] fg_base1,
  input  logic [AW-1:0] vid_base0,
  input  logic [AW-1:0] vid_base1,
  input  logic [AW-1:0] vid_base2,
  input  logic [AW-1:0] cur_base0,
  input  logic [AW-1:0] cur_base1,
  input  logic [XW-1:0] bg_x0,
  input  logic [YW-1:0] bg_y0,
  input  logic [YW-1:0] bg_h,
  input  logic          pix16,
  input  logic          wide,
  input  logic          vid_ycc,
  input  logic [XW-1:0] vid_w,
  input  logic [YW-1:0] vid_h,
  input  logic [XW-1:0] x,
  input  logic [YW-1:0] y,
  input  logic [4:0]    req,
  output logic [AW-1:0] addr_fg,
  output logic [AW-1:0] addr_bg,
  output logic [AW-1:0] addr_vid,
  output logic [AW-1:0] addr_cur0,
  output logic [AW-1:0] addr_cur1,
  output logic [4:0]    vld
);
  localparam int CW = $clog2(CUR);

  logic       fg_act;
  logic [1:0] vid_act;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fg_act  <= 1'b0;
      vid_act <= 2'd0;
    end else if (frame_start) begin
      fg_act <= fg_sel;
      if (vid_sel != 2'd3) vid_act <= vid_sel;
    end

  logic [XW-1:0] line_mask;
  logic          fg_in, vid_in, cur_in;
  logic [AW-1:0] fg_org, vid_org;
  logic [AW-1:0] fg_off, bg_off, vid_off, cur_off;
  logic [XW-1:0] bg_col;
  logic [YW:0]   bg_ysum;
  logic [YW-1:0] bg_row;

  assign line_mask = wide ? XW'(1023) : XW'(511);
  assign fg_in  = (x & ~line_mask) == '0;
  assign vid_in = (x < vid_w) && (y < vid_h);
  assign cur_in = (x < XW'(CUR)) && (y < YW'(CUR));

  assign fg_org  = fg_act ? fg_base1 : fg_base0;
  assign vid_org = (vid_act == 2'd2) ? vid_base2 :
                   (vid_act == 2'd1) ? vid_base1 : vid_base0;

  assign fg_off  = (AW'(y) << (wide ? 10 : 9)) + AW'(x);

  assign bg_col  = (x + bg_x0) & line_mask;
  assign bg_ysum = {1'b0, y} + {1'b0, bg_y0};
  assign bg_row  = (bg_ysum >= {1'b0, bg_h}) ? YW'(bg_ysum - {1'b0, bg_h}) : YW'(bg_ysum);
  assign bg_off  = (AW'(bg_row) << (wide ? 10 : 9)) + AW'(bg_col);

  assign vid_off = AW'(y) * AW'(vid_w) + AW'(x);
  assign cur_off = (AW'(y[CW-1:0]) << CW) | AW'(x[CW-1:0]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vld       <= '0;
      addr_fg   <= '0;
      addr_bg   <= '0;
      addr_vid  <= '0;
      addr_cur0 <= '0;
      addr_cur1 <= '0;
    end else begin
      vld       <= req & {cur_in, cur_in, vid_in, 1'b1, fg_in};
      addr_fg   <= fg_org + (pix16 ? fg_off << 1 : fg_off);
      addr_bg   <= pix16 ? bg_off << 1 : bg_off;
      addr_vid  <= vid_org + (vid_ycc ? vid_off << 1 : vid_off);
      addr_cur0 <= cur_base0 + cur_off;
      addr_cur1 <= cur_base1 + cur_off;
    end
endmodule

// File: rtl/disp_addr_gen_chk.sv
module disp_addr_gen_chk #(
  parameter int AW  = 32,
  parameter int XW  = 11,
  parameter int YW  = 10,
  parameter int CUR = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_start,
  input logic [1:0]    vid_sel,
  input logic          fg_act,
  input logic [1:0]    vid_act,
  input logic [XW-1:0] x,
  input logic [YW-1:0] y,
  input logic [XW-1:0] vid_w,
  input logic [YW-1:0] vid_h,
  input logic [4:0]    req,
  input logic [4:0]    vld,
  input logic [AW-1:0] addr_cur0,
  input logic [AW-1:0] cur_base0
);
  a_r2_vld_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (vld & ~$past(req)) == 5'd0);

  a_r4_fg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_start) |-> $stable(fg_act));

  a_r4_vid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_start) |-> $stable(vid_act));

  a_r5_vid_sel3_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_start && vid_sel == 2'd3) |-> $stable(vid_act));

  a_r9_vid_window: assert property (@(posedge clk) disable iff (!rst_n)
    vld[2] |-> $past(x < vid_w && y < vid_h));

  a_r10_cur_window: assert property (@(posedge clk) disable iff (!rst_n)
    vld[3] |-> $past(x < XW'(CUR) && y < YW'(CUR)));

  a_r10_cur_range: assert property (@(posedge clk) disable iff (!rst_n)
    vld[3] |-> (addr_cur0 - $past(cur_base0)) < AW'(CUR * CUR));
endmodule

bind disp_addr_gen disp_addr_gen_chk #(.AW(AW), .XW(XW), .YW(YW), .CUR(CUR)) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .vid_sel(vid_sel),
  .fg_act(fg_act), .vid_act(vid_act), .x(x), .y(y), .vid_w(vid_w), .vid_h(vid_h),
  .req(req), .vld(vld), .addr_cur0(addr_cur0), .cur_base0(cur_base0)
);

// File: tb/disp_addr_gen_tb.sv
module disp_addr_gen_tb_top;
  logic        clk = 0, rst_n = 0, frame_start = 0, fg_sel = 0;
  logic [1:0]  vid_sel = 0;
  logic [31:0] fg_base0 = 32'h1000, fg_base1 = 32'h80000;
  logic [31:0] vid_base0 = 32'h2000, vid_base1 = 32'h40000, vid_base2 = 32'h60000;
  logic [31:0] cur_base0 = 32'h300, cur_base1 = 32'h700;
  logic [10:0] bg_x0 = 0, vid_w = 11'd100, x = 0;
  logic [9:0]  bg_y0 = 0, bg_h = 10'd100, vid_h = 10'd50, y = 0;
  logic        pix16 = 0, wide = 0, vid_ycc = 0;
  logic [4:0]  req = 0;
  logic [31:0] addr_fg, addr_bg, addr_vid, addr_cur0, addr_cur1;
  logic [4:0]  vld;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  disp_addr_gen dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fire(input logic [4:0] r, input int xx, input int yy);
    @(negedge clk); req = r; x = 11'(xx); y = 10'(yy);
    @(posedge clk); #1; req = 0;
  endtask

  task automatic frame();
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
  endtask

  task automatic t_reset();
    repeat (2) @(posedge clk);
    #1 chk("R1 vld in reset", 32'(vld), 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1 chk("R1 vld after reset", 32'(vld), 0);
  endtask

  task automatic t_fg();
    pix16 = 0; wide = 0;
    fire(5'b00001, 5, 3);
    chk("R2 only fg vld", 32'(vld), 32'h1);
    chk("R3 fg 8bpp 512", addr_fg, 32'h1000 + 3*512 + 5);
    @(posedge clk); #1 chk("R2 vld drops", 32'(vld), 0);
    pix16 = 1; wide = 1;
    fire(5'b00001, 5, 3);
    chk("R3 fg 16bpp 1024", addr_fg, 32'h1000 + (3*1024 + 5)*2);
    wide = 0;
    fire(5'b00001, 600, 3);
    chk("R3 fg x beyond line", 32'(vld[0]), 0);
    pix16 = 0;
  endtask

  task automatic t_sel();
    @(negedge clk); fg_sel = 1; vid_sel = 2;
    fire(5'b00101, 1, 0);
    chk("R4 fg sel before frame", addr_fg, 32'h1001);
    chk("R4 vid sel before frame", addr_vid, 32'h2001);
    frame();
    fire(5'b00101, 1, 0);
    chk("R4 fg sel after frame", addr_fg, 32'h80001);
    chk("R4 vid sel after frame", addr_vid, 32'h60001);
    @(negedge clk); vid_sel = 3;
    frame();
    fire(5'b00100, 1, 0);
    chk("R5 vid sel 3 ignored", addr_vid, 32'h60001);
    @(negedge clk); vid_sel = 0; fg_sel = 0;
    frame();
  endtask

  task automatic t_bg();
    bg_x0 = 11'd500; bg_y0 = 10'd5; bg_h = 10'd100; wide = 0; pix16 = 0;
    fire(5'b00010, 20, 2);
    chk("R6 bg x wrap", addr_bg, 7*512 + 8);
    chk("R6 bg vld", 32'(vld), 32'h2);
    bg_y0 = 10'd90;
    fire(5'b00010, 20, 15);
    chk("R7 bg y wrap", addr_bg, 5*512 + 8);
    pix16 = 1; wide = 1;
    fire(5'b00010, 20, 15);
    chk("R7 bg 16bpp 1024", addr_bg, (5*1024 + 520)*2);
    pix16 = 0; wide = 0;
  endtask

  task automatic t_vid();
    vid_ycc = 1;
    fire(5'b00100, 10, 2);
    chk("R8 vid ycc", addr_vid, 32'h2000 + 210*2);
    vid_ycc = 0;
    fire(5'b00100, 10, 2);
    chk("R8 vid rgb", addr_vid, 32'h2000 + 210);
    chk("R9 vid inside", 32'(vld), 32'h4);
    fire(5'b00100, 99, 49);
    chk("R9 vid last pixel", 32'(vld[2]), 1);
    fire(5'b00100, 100, 2);
    chk("R9 vid x out", 32'(vld[2]), 0);
    fire(5'b00100, 10, 50);
    chk("R9 vid y out", 32'(vld[2]), 0);
  endtask

  task automatic t_cur();
    fire(5'b11000, 31, 31);
    chk("R10 cur0 corner", addr_cur0, 32'h300 + 1023);
    chk("R10 cur1 corner", addr_cur1, 32'h700 + 1023);
    chk("R10 cur vld", 32'(vld), 32'h18);
    fire(5'b10000, 1, 2);
    chk("R10 cur1 addr", addr_cur1, 32'h741);
    fire(5'b01000, 32, 0);
    chk("R10 cur x out", 32'(vld[3]), 0);
    fire(5'b01000, 0, 32);
    chk("R10 cur y out", 32'(vld[3]), 0);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_fg();
    t_sel();
    t_bg();
    t_vid();
    t_cur();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule